// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command pins from reset until the memory may be used. It keeps clock-enable asserted and the data mask set. For a settling interval it sends only no-operation commands. The interval is a parameter given as clock frequency in MHz times microseconds, and the usual value is 200 µs. After the interval it sends the start-up commands: one precharge of every bank, two or more auto-refresh commands, and a load of the mode register with a mode word supplied on an input. Each command is followed by its own spacing, counted in clock cycles, and no-operation commands fill the gap.

A parameter chooses which comes first after the precharge: the refresh group or the mode-register load. The refresh count is a parameter, and any value below two is raised to two. When the last spacing has run out, `init_done` rises and the data mask is released in the same cycle. From then on the block sends only no-operation commands, so a normal-operation controller can take over the bus.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held and until `init_done` rises, `cke` is 1 and every `dqm` bit is 1. `cke` stays 1 at all times.
- R2: Let W = CLK_MHZ*WAIT_US. Counting the rising edges that sample `rst_n` high, every command before edge W is NOP ({cs_n,ras_n,cas_n,we_n} = 0111).
- R3: The cycle after edge W carries the only precharge-all: command 0010, `addr[AP_BIT]` = 1, all other address bits 0, `ba` = 0.
- R4: The block issues exactly max(REFRESH_COUNT,2) auto-refresh commands (0001, addr 0, ba 0). Consecutive refreshes are T_RC cycles apart.
- R5: The mode-register load is command 0000. It drives `mode_word` on `addr` with bit AP_BIT forced to 0, and `ba` is 0.
- R6: With MRS_FIRST = 0, the first refresh comes T_RP cycles after the precharge, and the mode load comes T_RC cycles after the last refresh.
- R7: With MRS_FIRST = 1, the mode load comes T_RP cycles after the precharge, and the first refresh comes T_MRD cycles after the mode load.
- R8: `init_done` rises when the gap after the final command ends: T_MRD cycles after a final mode load, or T_RC cycles after a final refresh. `dqm` falls to 0 in that same cycle. Both then hold, and only NOP follows.
- R9: Every cycle that carries no command listed above is NOP, with `addr` = 0 and `ba` = 0.
- R10: If reset is asserted part-way through, the outputs return to the reset state, and after release the whole sequence restarts from the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_word | input | ADDR_W | Value loaded into the mode register |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dqm | output | DQM_W | Data mask, all ones until ready |
| addr | output | ADDR_W | Address bus |
| ba | output | BANK_W | Bank select |
| init_done | output | 1 | Memory ready for normal use |

## Verification
Two copies run side by side. One uses the default order with three refreshes. The other uses the swapped order with a refresh count of one, so it must raise the count to two; comparing the two copies separates an ordering fault from a refresh-count fault. Each copy is driven through a table of mode words: an ordinary value, all ones, only the reserved bit set, and a sparse pattern. A leak of the reserved bit shows up only on the words where that bit is set, and a dropped or shifted bit shows up on the others. Every cycle of each trace is compared with a cycle-exact model of the command timeline. A final run asserts reset in the middle of the refresh group to show that the sequence restarts cleanly.

// File: rtl/sdram_init_pkg.sv
// Shared encodings for the SDRAM start-up sequencer.
// Assumes commands are driven as {cs_n, ras_n, cas_n, we_n}.
package sdram_init_pkg;

    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;
    localparam logic [3:0] CMD_MRS = 4'b0000;

    typedef enum logic [2:0] {
        ST_WAIT = 3'd0,
        ST_PRE  = 3'd1,
        ST_REF  = 3'd2,
        ST_MRS  = 3'd3,
        ST_DONE = 3'd4
    } step_t;

endpackage

// File: rtl/sdram_init_timer.sv
// Step timer. It counts the cycles spent in the current step and flags the
// first cycle (the one that carries the command) and the last cycle.
// Assumes limit_m1 only changes in the cycle that follows a 'last' pulse.
module sdram_init_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [CNT_W-1:0] limit_m1,
    output logic             first,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    // Count up within a step, and wrap to zero at the step's end or while held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign first = (cnt == '0);
    assign last  = (cnt == limit_m1);

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit_m1);

endmodule

// File: rtl/sdram_init_ctrl.sv
// Step sequencer. It walks through wait, precharge, refresh group and mode load,
// in the order that MRS_FIRST selects, and supplies the length of each step to
// the timer. Assumes all lengths are already clamped to at least 1 and REF_N >= 2.
module sdram_init_ctrl
    import sdram_init_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int WAIT_CYC  = 100,
    parameter int RP_CYC    = 3,
    parameter int RC_CYC    = 9,
    parameter int MRD_CYC   = 2,
    parameter int REF_N     = 2,
    parameter bit MRS_FIRST = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             last,
    output step_t            step,
    output logic             hold,
    output logic [CNT_W-1:0] limit_m1
);

    localparam int RW = (REF_N > 2) ? $clog2(REF_N) : 1;
    localparam logic [RW-1:0] REF_LAST = RW'(REF_N - 1);
    localparam step_t AFTER_PRE = MRS_FIRST ? ST_MRS : ST_REF;
    localparam step_t AFTER_REF = MRS_FIRST ? ST_DONE : ST_MRS;
    localparam step_t AFTER_MRS = MRS_FIRST ? ST_REF : ST_DONE;

    logic [RW-1:0] ref_idx;

    // Move to the next step at the end of each step's window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step    <= ST_WAIT;
            ref_idx <= '0;
        end else if (last && step != ST_DONE) begin
            case (step)
                ST_WAIT: step <= ST_PRE;
                ST_PRE:  step <= AFTER_PRE;
                ST_REF: begin
                    if (ref_idx == REF_LAST) begin
                        ref_idx <= '0;
                        step    <= AFTER_REF;
                    end else begin
                        ref_idx <= ref_idx + 1'b1;
                    end
                end
                ST_MRS:  step <= AFTER_MRS;
                default: step <= ST_DONE;
            endcase
        end
    end

    // Select the window length for the current step.
    always_comb begin
        case (step)
            ST_WAIT: limit_m1 = CNT_W'(WAIT_CYC - 1);
            ST_PRE:  limit_m1 = CNT_W'(RP_CYC - 1);
            ST_REF:  limit_m1 = CNT_W'(RC_CYC - 1);
            ST_MRS:  limit_m1 = CNT_W'(MRD_CYC - 1);
            default: limit_m1 = '0;
        endcase
    end

    assign hold = (step == ST_DONE);

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step == ST_DONE |=> step == ST_DONE);

    // R4
    ref_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_idx <= REF_LAST);

    // R6
    // R7
    order_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_PRE && last) |=> step == AFTER_PRE);

endmodule

// File: rtl/sdram_init_drive.sv
// Pin driver. It turns the current step and the timer's first-cycle flag into
// the command, address, bank, clock-enable and mask outputs.
// Assumes AP_BIT < ADDR_W. Purely combinational.
module sdram_init_drive
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int BANK_W = 1,
    parameter int DQM_W  = 2,
    parameter int AP_BIT = 10
) (
    input  step_t              step,
    input  logic               first,
    input  logic [ADDR_W-1:0]  mode_word,
    output logic [3:0]         cmd,
    output logic [ADDR_W-1:0]  addr,
    output logic [BANK_W-1:0]  ba,
    output logic               cke,
    output logic [DQM_W-1:0]   dqm,
    output logic               done
);

    // Put the step's command on the bus in its first cycle, and NOP otherwise.
    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        ba   = '0;
        if (first) begin
            case (step)
                ST_PRE: begin
                    cmd          = CMD_PRE;
                    addr[AP_BIT] = 1'b1;
                end
                ST_REF: cmd = CMD_REF;
                ST_MRS: begin
                    cmd          = CMD_MRS;
                    addr         = mode_word;
                    addr[AP_BIT] = 1'b0;
                end
                default: cmd = CMD_NOP;
            endcase
        end
    end

    assign cke  = 1'b1;
    assign done = (step == ST_DONE);
    assign dqm  = {DQM_W{step != ST_DONE}};

endmodule

// File: rtl/sdram_init_seq.sv
// Top level of the SDRAM start-up sequencer. It clamps the parameters, links
// the step sequencer, the step timer and the pin driver, and holds the checks
// that span the whole command timeline.
// Assumes mode_word is stable from the mode-load cycle onward.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ       = 100,
    parameter int WAIT_US       = 200,
    parameter int T_RP          = 3,
    parameter int T_RC          = 9,
    parameter int T_MRD         = 2,
    parameter int REFRESH_COUNT = 2,
    parameter bit MRS_FIRST     = 1'b0,
    parameter int ADDR_W        = 11,
    parameter int BANK_W        = 1,
    parameter int DQM_W         = 2,
    parameter int AP_BIT        = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [DQM_W-1:0]  dqm,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba,
    output logic              init_done
);

    localparam int WAIT_CYC = (CLK_MHZ * WAIT_US < 1) ? 1 : CLK_MHZ * WAIT_US;
    localparam int RP_CYC   = (T_RP < 1) ? 1 : T_RP;
    localparam int RC_CYC   = (T_RC < 1) ? 1 : T_RC;
    localparam int MRD_CYC  = (T_MRD < 1) ? 1 : T_MRD;
    localparam int REF_N    = (REFRESH_COUNT < 2) ? 2 : REFRESH_COUNT;
    localparam int MAX_A    = (WAIT_CYC > RP_CYC) ? WAIT_CYC : RP_CYC;
    localparam int MAX_B    = (RC_CYC > MRD_CYC) ? RC_CYC : MRD_CYC;
    localparam int MAX_L    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W    = $clog2(MAX_L + 1);
    localparam int RCW      = $clog2(REF_N + 1);

    step_t            step;
    logic             hold;
    logic             first;
    logic             last;
    logic [CNT_W-1:0] limit_m1;
    logic [3:0]       cmd_bus;

    sdram_init_ctrl #(
        .CNT_W     (CNT_W),
        .WAIT_CYC  (WAIT_CYC),
        .RP_CYC    (RP_CYC),
        .RC_CYC    (RC_CYC),
        .MRD_CYC   (MRD_CYC),
        .REF_N     (REF_N),
        .MRS_FIRST (MRS_FIRST)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .last     (last),
        .step     (step),
        .hold     (hold),
        .limit_m1 (limit_m1)
    );

    sdram_init_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .limit_m1 (limit_m1),
        .first    (first),
        .last     (last)
    );

    sdram_init_drive #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .DQM_W  (DQM_W),
        .AP_BIT (AP_BIT)
    ) u_drive (
        .step      (step),
        .first     (first),
        .mode_word (mode_word),
        .cmd       (cmd_bus),
        .addr      (addr),
        .ba        (ba),
        .cke       (cke),
        .dqm       (dqm),
        .done      (init_done)
    );

    assign {cs_n, ras_n, cas_n, we_n} = cmd_bus;

    // Checker state: cycles since reset release (saturating) and refreshes seen.
    logic [CNT_W-1:0] chk_age;
    logic [RCW-1:0]   chk_refs;

    // Track elapsed cycles and issued refreshes for the timeline checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_age  <= '0;
            chk_refs <= '0;
        end else begin
            if (chk_age != CNT_W'(WAIT_CYC)) chk_age <= chk_age + 1'b1;
            if (cmd_bus == CMD_REF && chk_refs != RCW'(REF_N)) chk_refs <= chk_refs + 1'b1;
        end
    end

    // R2
    wait_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_bus != CMD_NOP |-> chk_age == CNT_W'(WAIT_CYC));

    // R3
    pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_bus == CMD_PRE |-> addr[AP_BIT] && ba == '0);

    // R4
    ref_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> chk_refs == RCW'(REF_N));

    // R5
    mrs_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_bus == CMD_MRS |-> !addr[AP_BIT] && ba == '0);

    // R8
    dqm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dqm[0]) |-> $rose(init_done));

    // R1
    cke_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> cke && (&dqm));

endmodule

// File: tb/sdram_init_seq_test.sv
// Bench for the SDRAM start-up sequencer: two copies, one per step order.
module sdram_init_seq_test;

    localparam int W    = 250;   // 250 MHz x 1 us
    localparam int RP   = 3;
    localparam int RC   = 7;
    localparam int LEN  = W + 60;
    localparam int NVEC = 4;
    // {mode word, expected address during the mode load}
    localparam logic [21:0] VEC [NVEC] = '{
        {11'h033, 11'h033},
        {11'h7FF, 11'h3FF},
        {11'h400, 11'h000},
        {11'h222, 11'h222}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] mode_word = '0;
    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic        a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [1:0]  a_dqm;
    logic [10:0] a_addr;
    logic [0:0]  a_ba;
    logic        b_cke, b_cs, b_ras, b_cas, b_we, b_done;
    logic [1:0]  b_dqm;
    logic [10:0] b_addr;
    logic [0:0]  b_ba;

    always #2 clk = ~clk;

    sdram_init_seq #(
        .CLK_MHZ(250), .WAIT_US(1), .T_RP(RP), .T_RC(RC), .T_MRD(2),
        .REFRESH_COUNT(3), .MRS_FIRST(1'b0)
    ) uut (
        .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .cke(a_cke),
        .cs_n(a_cs), .ras_n(a_ras), .cas_n(a_cas), .we_n(a_we), .dqm(a_dqm),
        .addr(a_addr), .ba(a_ba), .init_done(a_done)
    );

    sdram_init_seq #(
        .CLK_MHZ(250), .WAIT_US(1), .T_RP(RP), .T_RC(RC), .T_MRD(4),
        .REFRESH_COUNT(1), .MRS_FIRST(1'b1)
    ) uut_swap (
        .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .cke(b_cke),
        .cs_n(b_cs), .ras_n(b_ras), .cas_n(b_cas), .we_n(b_we), .dqm(b_dqm),
        .addr(b_addr), .ba(b_ba), .init_done(b_done)
    );

    // Kind of cycle j: 0 wait, 1 precharge, 2 refresh, 3 mode load, 4 ready, 5 gap
    function automatic int exp_kind(int j, bit swap, int n, int mrd);
        int t, done_at, mrs_at, ref_base;
        if (j < W) return 0;
        t = j - W;
        if (t == 0) return 1;
        done_at  = RP + n * RC + mrd;
        if (t >= done_at) return 4;
        mrs_at   = swap ? RP : RP + n * RC;
        ref_base = swap ? RP + mrd : RP;
        if (t == mrs_at) return 3;
        if (t >= ref_base && (t - ref_base) % RC == 0 && (t - ref_base) / RC < n) return 2;
        return 5;
    endfunction

    task automatic check_one(string tag, int j, bit swap, int n, int mrd,
                             logic [3:0] cmd, logic [10:0] addr, logic [0:0] ba,
                             logic cke, logic [1:0] dqm, logic done, logic [10:0] mrs_addr);
        int k;
        logic [3:0]  e_cmd;
        logic [10:0] e_addr;
        logic        e_done;
        string req;
        k = exp_kind(j, swap, n, mrd);
        e_cmd = 4'b0111; e_addr = '0; e_done = 1'b0;
        case (k)
            0: req = "R1 R2";
            1: begin e_cmd = 4'b0010; e_addr = 11'h400; req = "R3"; end
            2: begin e_cmd = 4'b0001; req = swap ? "R4 R7" : "R4 R6"; end
            3: begin e_cmd = 4'b0000; e_addr = mrs_addr; req = swap ? "R5 R7" : "R5 R6"; end
            4: begin e_done = 1'b1; req = "R8"; end
            default: req = "R9";
        endcase
        checks++;
        if (cmd !== e_cmd || addr !== e_addr || ba !== 1'b0 || cke !== 1'b1 ||
            dqm !== {2{~e_done}} || done !== e_done) begin
            failures++;
            $display("FAIL %s %s cycle %0d: cmd=%b addr=%h ba=%b cke=%b dqm=%b done=%b expected cmd=%b addr=%h ba=0 cke=1 dqm=%b done=%b",
                     req, tag, j, cmd, addr, ba, cke, dqm, done, e_cmd, e_addr, {2{~e_done}}, e_done);
        end
    endtask

    task automatic check_reset(string tag, logic [3:0] cmd, logic [10:0] addr,
                               logic cke, logic [1:0] dqm, logic done);
        checks++;
        if (cmd !== 4'b0111 || addr !== '0 || cke !== 1'b1 || dqm !== 2'b11 || done !== 1'b0) begin
            failures++;
            $display("FAIL R1 R10 %s reset: cmd=%b addr=%h cke=%b dqm=%b done=%b expected cmd=0111 addr=000 cke=1 dqm=11 done=0",
                     tag, cmd, addr, cke, dqm, done);
        end
    endtask

    // Reset both copies, then compare every cycle up to cycle 'upto'.
    task automatic run_trace(logic [10:0] mw, logic [10:0] mrs_addr, int upto);
        @(negedge clk);
        rst_n = 1'b0;
        mode_word = mw;
        repeat (3) begin
            @(negedge clk);
            check_reset("uut", {a_cs, a_ras, a_cas, a_we}, a_addr, a_cke, a_dqm, a_done);
            check_reset("uut_swap", {b_cs, b_ras, b_cas, b_we}, b_addr, b_cke, b_dqm, b_done);
        end
        for (int j = 0; j <= upto; j++) begin
            if (j > 0) @(negedge clk);
            check_one("uut", j, 1'b0, 3, 2, {a_cs, a_ras, a_cas, a_we}, a_addr, a_ba,
                      a_cke, a_dqm, a_done, mrs_addr);
            check_one("uut_swap", j, 1'b1, 2, 4, {b_cs, b_ras, b_cas, b_we}, b_addr, b_ba,
                      b_cke, b_dqm, b_done, mrs_addr);
            if (j == 0) rst_n = 1'b1;
        end
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        // Table walk: full timelines for each mode word (R1 to R9)
        for (int v = 0; v < NVEC; v++) begin
            run_trace(VEC[v][21:11], VEC[v][10:0], LEN);
        end
        // R10: stop part-way through the refresh group, then reset and rerun
        run_trace(11'h155, 11'h155, W + RP + RC + 2);
        run_trace(11'h2AA, 11'h2AA, LEN);
        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            report();
            $finish;
        end
    end

endmodule